// File: doc/BRIEF.md
# Dual-Bank Write Status Reporter

This block sits beside the read path of a two-bank flash array and reports on a program or erase that runs in the background. When the command front end accepts the final cycle of a write sequence, it hands the block the kind of operation, the bank it targets and the word being programmed. From then until an internal cycle timer expires, a read aimed at the busy bank returns a status word instead of array contents. A read aimed at the other bank passes array data straight through, so code can keep running from one bank while the other is being updated.

The status word carries two flags. The polling flag on bit 7 shows the inverse of bit 7 of the word being programmed, or 0 while an erase runs. The toggle flag on bit 6 changes value on every status read. All other status bits are driven as 0. A ready/busy request output asks the board-level open-drain pin to pull low while an operation runs or while an identification/query read mode is active. It lets go whenever output enable or chip enable is inactive, and while reset is held. Reset abandons any running operation.

Top module: `bank_wr_status`

## Requirements
- R1: While reset is held and right after it, the read data output is 0, the read valid flag is low, the pull-low request is low and no bank is busy, so the first read of either bank returns array data.
- R2: While a program is running, a read of its bank returns bit 7 equal to the inverse of bit 7 of the programmed word, and every bit other than 7 and 6 equal to 0.
- R3: While an erase is running, a read of its bank returns bit 7 equal to 0, and every bit other than 7 and 6 equal to 0.
- R4: The first status read after each accepted start returns bit 6 equal to 0. Each further status read of the same operation returns the inverse of the previous one.
- R5: A program stays busy for PROG_CYCLES clock cycles after the edge that accepts it, and an erase for ERASE_CYCLES. After that, reads return array data and the pull-low request drops.
- R6: A read of the bank that is not busy returns the array data unchanged, and it does not advance the toggle flag.
- R7: The pull-low request is high exactly when output enable (active low) and chip enable (active low) are both low, reset is low, and either an operation runs or the identification mode input is high.
- R8: Asserting reset for one cycle ends a running operation. The next read of its bank returns array data, and the pull-low request is low.
- R9: A start request made while an operation runs is ignored. The running operation keeps its bank, its kind, its polling value and its end cycle.
- R10: Read data and the read valid flag appear on the clock edge that samples the read strobe. In a cycle with no read strobe, the valid flag is low on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_vld | input | 1 | Final command cycle accepted; start an operation |
| start_erase | input | 1 | Kind of operation: 1 erase, 0 program |
| start_bank | input | BANK_W | Bank targeted by the operation |
| prog_word | input | DW | Word being programmed (only bit 7 is used) |
| id_mode | input | 1 | Identification/query read mode active |
| oe_n | input | 1 | Output enable, active low |
| ce_n | input | 1 | Chip enable, active low |
| rd_en | input | 1 | Read strobe, one cycle per read |
| rd_bank | input | BANK_W | Bank addressed by the read |
| arr_data | input | DW | Array contents at the read address |
| rd_data | output | DW | Registered read result |
| rd_vld | output | 1 | Read result valid |
| rdy_pull_low | output | 1 | Request to pull ready/busy low |

## Verification
The assertions assume that reset is a clean synchronous pulse and that every control input is stable around the sampling edge. They also assume that DW is at least 8, so that bits 7 and 6 exist. The bench drives all inputs on the falling edge and holds each read strobe for exactly one cycle, so each strobe maps to one sampled read. Start requests made during an operation are issued on purpose to exercise R9. A start and a status read on the same edge never occur, because a status read needs a running operation and a start is only accepted when none runs.

// File: rtl/wsr_pkg.sv
`timescale 1ns/1ps
package wsr_pkg;

    typedef enum logic {
        OP_PROG  = 1'b0,
        OP_ERASE = 1'b1
    } wr_op_e;

    // Everything the status word needs about the running job
    typedef struct packed {
        wr_op_e op;
        logic   prog_b7;
    } job_t;

    localparam int POLL_BIT = 7;
    localparam int TGL_BIT  = 6;

    // Low byte of a status read; upper bits are zero-filled by the caller
    function automatic logic [7:0] status_byte(input job_t j, input logic tgl);
        logic [7:0] s;
        s           = 8'h00;
        s[POLL_BIT] = (j.op == OP_PROG) ? ~j.prog_b7 : 1'b0;
        s[TGL_BIT]  = tgl;
        return s;
    endfunction

    function automatic int bank_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/wsr_timer.sv
`timescale 1ns/1ps
module wsr_timer
    import wsr_pkg::*;
#(
    parameter int BANK_W       = 1,
    parameter int PROG_CYCLES  = 500,
    parameter int ERASE_CYCLES = 2000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_vld,
    input  wr_op_e            start_op,
    input  logic [BANK_W-1:0] start_bank,
    input  logic              start_b7,
    output logic              active,
    output logic              accepted,
    output job_t              job,
    output logic [BANK_W-1:0] job_bank
);
    localparam int MAX_CYC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
    localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
    localparam logic [CNT_W-1:0] PG_LD = CNT_W'(PROG_CYCLES - 1);
    localparam logic [CNT_W-1:0] ER_LD = CNT_W'(ERASE_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    assign accepted = start_vld && !active;

    always_ff @(posedge clk) begin
        if (rst) begin
            active   <= 1'b0;
            cnt      <= '0;
            job      <= '{op: OP_PROG, prog_b7: 1'b0};
            job_bank <= '0;
        end else if (!active) begin
            if (start_vld) begin
                active   <= 1'b1;
                cnt      <= (start_op == OP_ERASE) ? ER_LD : PG_LD;
                job      <= '{op: start_op, prog_b7: start_b7};
                job_bank <= start_bank;
            end
        end else if (cnt == '0) begin
            active <= 1'b0;
        end else begin
            cnt <= cnt - 1'b1;
        end
    end

    AST_DONE_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        $fell(active) && !$past(rst) |-> $past(cnt) == '0); // R5
    AST_RST_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !active); // R8
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        active && start_vld |=> job == $past(job) && job_bank == $past(job_bank)); // R9

endmodule

// File: rtl/wsr_toggle.sv
`timescale 1ns/1ps
module wsr_toggle (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic advance,
    output logic tgl
);
    always_ff @(posedge clk) begin
        if (rst || restart) tgl <= 1'b0;
        else if (advance)   tgl <= ~tgl;
    end

    AST_TGL_FLIP: assert property (@(posedge clk) disable iff (rst)
        advance && !restart |=> tgl != $past(tgl)); // R4
    AST_TGL_HOLD: assert property (@(posedge clk) disable iff (rst)
        !advance && !restart |=> $stable(tgl)); // R6

endmodule

// File: rtl/wsr_rdport.sv
`timescale 1ns/1ps
module wsr_rdport
    import wsr_pkg::*;
#(
    parameter int DW     = 16,
    parameter int BANK_W = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [BANK_W-1:0] rd_bank,
    input  logic [DW-1:0]     arr_data,
    input  logic              active,
    input  job_t              job,
    input  logic [BANK_W-1:0] job_bank,
    input  logic              tgl,
    output logic              status_rd,
    output logic [DW-1:0]     rd_data,
    output logic              rd_vld
);
    logic [DW-1:0] stat_word;
    logic [DW-1:0] next_data;

    assign status_rd = rd_en && active && (rd_bank == job_bank);

    generate
        if (DW > 8) begin : g_wide
            assign stat_word = {{(DW-8){1'b0}}, status_byte(job, tgl)};
        end else begin : g_byte
            assign stat_word = status_byte(job, tgl);
        end
    endgenerate

    always_comb begin
        next_data = status_rd ? stat_word : arr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
            rd_vld  <= 1'b0;
        end else begin
            rd_vld <= rd_en;
            if (rd_en) rd_data <= next_data;
        end
    end

    AST_RD_LAT: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_vld); // R10
    AST_RD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !rd_vld); // R10
    AST_ERASE_POLL: assert property (@(posedge clk) disable iff (rst)
        status_rd && job.op == OP_ERASE |=> rd_data[7] == 1'b0); // R3
    AST_PASS_THRU: assert property (@(posedge clk) disable iff (rst)
        rd_en && !status_rd |=> rd_data == $past(arr_data)); // R6

endmodule

// File: rtl/bank_wr_status.sv
`timescale 1ns/1ps
module bank_wr_status
    import wsr_pkg::*;
#(
    parameter int DW           = 16,
    parameter int NUM_BANKS    = 2,
    parameter int PROG_CYCLES  = 500,
    parameter int ERASE_CYCLES = 2000,
    localparam int BANK_W      = bank_width(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_vld,
    input  logic              start_erase,
    input  logic [BANK_W-1:0] start_bank,
    input  logic [DW-1:0]     prog_word,
    input  logic              id_mode,
    input  logic              oe_n,
    input  logic              ce_n,
    input  logic              rd_en,
    input  logic [BANK_W-1:0] rd_bank,
    input  logic [DW-1:0]     arr_data,
    output logic [DW-1:0]     rd_data,
    output logic              rd_vld,
    output logic              rdy_pull_low
);
    logic              active;
    logic              accepted;
    job_t              job;
    logic [BANK_W-1:0] job_bank;
    logic              tgl;
    logic              status_rd;
    wr_op_e            start_op;
    logic              unused_bits;

    assign start_op    = start_erase ? OP_ERASE : OP_PROG;
    assign unused_bits = ^{prog_word[DW-1:8], prog_word[6:0]};

    wsr_timer #(
        .BANK_W      (BANK_W),
        .PROG_CYCLES (PROG_CYCLES),
        .ERASE_CYCLES(ERASE_CYCLES)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .start_vld (start_vld),
        .start_op  (start_op),
        .start_bank(start_bank),
        .start_b7  (prog_word[7]),
        .active    (active),
        .accepted  (accepted),
        .job       (job),
        .job_bank  (job_bank)
    );

    wsr_toggle u_toggle (
        .clk    (clk),
        .rst    (rst),
        .restart(accepted),
        .advance(status_rd),
        .tgl    (tgl)
    );

    wsr_rdport #(
        .DW    (DW),
        .BANK_W(BANK_W)
    ) u_rdport (
        .clk      (clk),
        .rst      (rst),
        .rd_en    (rd_en),
        .rd_bank  (rd_bank),
        .arr_data (arr_data),
        .active   (active),
        .job      (job),
        .job_bank (job_bank),
        .tgl      (tgl),
        .status_rd(status_rd),
        .rd_data  (rd_data),
        .rd_vld   (rd_vld)
    );

    assign rdy_pull_low = !rst && !oe_n && !ce_n && (active || id_mode);

    AST_RESTART_TGL: assert property (@(posedge clk) disable iff (rst)
        accepted |=> tgl == 1'b0); // R4

endmodule

// File: tb/sim_bank_wr_status.sv
`timescale 1ns/1ps
module sim_bank_wr_status;
    localparam int DW = 16;
    localparam int PG = 8;
    localparam int ER = 20;

    logic          clk = 1'b0;
    logic          rst, start_vld, start_erase, id_mode, oe_n, ce_n, rd_en;
    logic [0:0]    start_bank, rd_bank;
    logic [DW-1:0] prog_word, arr_data, rd_data;
    logic          rd_vld, rdy_pull_low;
    int            checks = 0;
    int            failures = 0;

    always #10 clk = ~clk;

    bank_wr_status #(.DW(DW), .NUM_BANKS(2), .PROG_CYCLES(PG), .ERASE_CYCLES(ER)) u0 (
        .clk(clk), .rst(rst), .start_vld(start_vld), .start_erase(start_erase),
        .start_bank(start_bank), .prog_word(prog_word), .id_mode(id_mode),
        .oe_n(oe_n), .ce_n(ce_n), .rd_en(rd_en), .rd_bank(rd_bank),
        .arr_data(arr_data), .rd_data(rd_data), .rd_vld(rd_vld),
        .rdy_pull_low(rdy_pull_low)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic start(input logic erase, input logic bank, input logic [DW-1:0] w);
        start_vld = 1'b1; start_erase = erase; start_bank = bank; prog_word = w;
        @(posedge clk); @(negedge clk);
        start_vld = 1'b0;
    endtask

    task automatic rd(input logic bank, input logic [DW-1:0] arr, input logic [DW-1:0] exp,
                      input string tag);
        rd_en = 1'b1; rd_bank = bank; arr_data = arr;
        @(posedge clk); @(negedge clk);
        rd_en = 1'b0;
        check({tag, " data"}, rd_data, exp);
        check("R10 valid", rd_vld, 1'b1);
    endtask

    task automatic t_reset();
        cycles(2);
        check("R1 data", rd_data, '0);
        check("R1 valid", rd_vld, 1'b0);
        check("R1 pull", rdy_pull_low, 1'b0);
        rst = 1'b0;
        rd(1'b0, 16'h2222, 16'h2222, "R1 first read");
        cycles(1);
        check("R10 idle valid", rd_vld, 1'b0);
    endtask

    task automatic t_program();
        start(1'b0, 1'b0, 16'h00A5);
        rd(1'b0, 16'hBEEF, 16'h0000, "R2 R4 status1");
        rd(1'b1, 16'h1234, 16'h1234, "R6 idle bank");
        rd(1'b0, 16'hBEEF, 16'h0040, "R4 status2");
        rd(1'b0, 16'hBEEF, 16'h0000, "R4 status3");
        cycles(3);
        check("R5 still busy", rdy_pull_low, 1'b1);
        cycles(1);
        check("R5 done pull", rdy_pull_low, 1'b0);
        rd(1'b0, 16'h00A5, 16'h00A5, "R5 array after");
    endtask

    task automatic t_program_b7_low();
        start(1'b0, 1'b1, 16'hFF33);
        rd(1'b1, 16'h0000, 16'h0080, "R2 R4 restart");
        rd(1'b1, 16'h0000, 16'h00C0, "R2 second");
        cycles(PG);
        rd(1'b1, 16'h7777, 16'h7777, "R5 program end");
    endtask

    task automatic t_erase();
        start(1'b1, 1'b1, 16'h00FF);
        rd(1'b1, 16'h1357, 16'h0000, "R3 erase1");
        rd(1'b1, 16'h1357, 16'h0040, "R3 erase2");
        cycles(ER - 3);
        check("R5 erase busy", rdy_pull_low, 1'b1);
        cycles(1);
        check("R5 erase done", rdy_pull_low, 1'b0);
        rd(1'b1, 16'hFFFF, 16'hFFFF, "R5 erased");
    endtask

    task automatic t_pull();
        start(1'b0, 1'b0, 16'h0000);
        check("R7 busy", rdy_pull_low, 1'b1);
        oe_n = 1'b1; #1;
        check("R7 oe high", rdy_pull_low, 1'b0);
        oe_n = 1'b0; ce_n = 1'b1; #1;
        check("R7 ce high", rdy_pull_low, 1'b0);
        ce_n = 1'b0;
        cycles(PG);
        check("R7 idle", rdy_pull_low, 1'b0);
        id_mode = 1'b1; #1;
        check("R7 id mode", rdy_pull_low, 1'b1);
        oe_n = 1'b1; #1;
        check("R7 id oe high", rdy_pull_low, 1'b0);
        oe_n = 1'b0; id_mode = 1'b0;
        cycles(1);
    endtask

    task automatic t_ignore();
        start(1'b0, 1'b1, 16'h0011);
        start(1'b1, 1'b0, 16'h0000);
        rd(1'b0, 16'h5A5A, 16'h5A5A, "R9 other bank");
        rd(1'b1, 16'h0000, 16'h0080, "R9 kept program");
        cycles(PG - 4);
        check("R9 still busy", rdy_pull_low, 1'b1);
        cycles(1);
        check("R9 original end", rdy_pull_low, 1'b0);
        rd(1'b0, 16'h6B6B, 16'h6B6B, "R9 no erase");
    endtask

    task automatic t_abort();
        start(1'b1, 1'b0, 16'h0000);
        rd(1'b0, 16'h1111, 16'h0000, "R8 pre status");
        rst = 1'b1;
        cycles(1);
        rst = 1'b0;
        check("R8 pull", rdy_pull_low, 1'b0);
        rd(1'b0, 16'h1111, 16'h1111, "R8 array");
    endtask

    initial begin
        #4_000_000;
        failures++; checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1; start_vld = 1'b0; start_erase = 1'b0; start_bank = '0;
        prog_word = '0; id_mode = 1'b0; oe_n = 1'b0; ce_n = 1'b0;
        rd_en = 1'b0; rd_bank = '0; arr_data = '0;
        @(negedge clk);
        t_reset();
        t_program();
        t_program_b7_low();
        t_erase();
        t_pull();
        t_ignore();
        t_abort();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule